// File: doc/BRIEF.md
# Debounced Three-Pin GPIO Port with SMI Gating

This block is a small general-purpose I/O port with three pads, controlled through a byte-wide register interface. Each pad has a direction bit and a data bit. A write to the data register changes only the pads that are set as outputs. A read returns the driven value for output pads and the recognized input level for input pads. Every pad input first passes through a two-flop synchronizer and then through a level filter. Pad 2 always uses a fixed filter of 31 µs. For pads 0 and 1, a configuration bit chooses between that filter and a direct path.

Pads 0 and 1 can each raise a system-management interrupt when their recognized level changes. This happens only when the pad is an input and its SMI enable bit is set. Setting the SMI enable takes the pad's change events away from the general event output, so those events appear only as SMI. All SMI events share one sticky status bit. Software clears that bit by writing 1 to it. The SMI output stays high as long as the status bit is set.

Top module: `gpio_smi_port`

## Requirements
- R1: After reset, the configuration, data and status registers read 00h, pad_oe_o and pad_out_o are 0, and smi_o is 0.
- R2: Configuration register (address 0) layout: bits [2:0] are the pad directions (1 = output), bits [4:3] are the SMI enables for pads 0 and 1, and bit 5 turns on the filter for pads 0 and 1. pad_oe_o equals the direction bits from the clock edge that commits the write onward.
- R3: A write to the data register (address 1) updates the driven value only of pads whose direction is output. The driven values of input pads keep their old value, and pad_out_o shows the driven values.
- R4: A read of data bit n returns the driven value when pad n is an output, and the recognized level when pad n is an input.
- R5: A change on pad 2 is recognized only after the synchronized level has been held for DB_CYCLES consecutive cycles (31 µs; 31 cycles at 1 MHz). A pad change set up before edge E1 shows up in the read after edge E(2+DB_CYCLES). A shorter pulse is never recognized.
- R6: With bit 5 = 0, pads 0 and 1 are recognized after edge E3. With bit 5 = 1, they follow the same timing as R5.
- R7: A recognized change on pad 0 or 1 sets the status bit (address 2, bit 0) at the same edge, provided the pad is an input and its SMI enable is set. smi_o is high while the status bit is set.
- R8: No SMI is raised by a pad whose direction is output or whose SMI enable is clear.
- R9: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R10: wake_evt_o[n] pulses for one cycle, in the cycle before the edge that updates the recognized level, when input pad n (n = 0 or 1) changes with its SMI enable clear. It stays 0 while that pad's SMI enable is set.
- R11: Reserved bits read as 0 and ignore writes: configuration bits [7:6], status bits [7:1], data bits [7:3], and all of address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pad_in_i | input | 3 | Pad input levels, asynchronous |
| pad_out_o | output | 3 | Pad output levels |
| pad_oe_o | output | 3 | Pad output enables |
| smi_o | output | 1 | SMI request level |
| wake_evt_o | output | 2 | Change events for the general event router |

## Verification
Register writes take effect at the edge that commits them. Reads are combinational, so each write check samples one cycle later, on the falling edge. For a pad change set up on a falling edge, the bench counts rising edges from that point. In the direct path, the recognized level, the status bit and smi_o are checked at edge E2, where they must still hold the old value, and at E3, where they must hold the new one. With the filter on, the same before-and-after pair is checked at E(1+DB_CYCLES) and E(2+DB_CYCLES). wake_evt_o is sampled just after E2, where the pulse is expected, and again after E3, where it must be gone. Glitch and no-effect cases wait well past the window and then read the register or the output that the stimulus could have changed.

// File: rtl/gpio_smi_pkg.sv
package gpio_smi_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_RSV  = 2'd3
  } reg_addr_e;

  localparam int unsigned STAT_SMI_BIT = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int unsigned DB_CYCLES = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic bypass_i,
  output logic level_o,
  output logic chg_o
);
  localparam int unsigned CNT_W = $clog2(DB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

  logic             level_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differ;

  assign differ = sync_i ^ level_q;
  // chg_o marks the cycle whose closing edge adopts the new level
  assign chg_o  = differ & (bypass_i | (cnt_q == CNT_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!differ || chg_o) begin
      cnt_q <= '0;
      if (chg_o) level_q <= sync_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/gpio_smi_port.sv
module gpio_smi_port
  import gpio_smi_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ  = 1_000_000,
  parameter int unsigned DEBOUNCE_US  = 31,
  parameter int unsigned NUM_PINS     = 3,
  parameter int unsigned NUM_SMI_PINS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wr_en_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [REG_W-1:0]        rdata_o,
  input  logic [NUM_PINS-1:0]     pad_in_i,
  output logic [NUM_PINS-1:0]     pad_out_o,
  output logic [NUM_PINS-1:0]     pad_oe_o,
  output logic                    smi_o,
  output logic [NUM_SMI_PINS-1:0] wake_evt_o
);
  localparam int unsigned CYC_PER_US = (CLK_FREQ_HZ + 999_999) / 1_000_000;
  localparam int unsigned DB_RAW     = CYC_PER_US * DEBOUNCE_US;
  localparam int unsigned DB_CYCLES  = (DB_RAW < 1) ? 1 : DB_RAW;
  localparam int unsigned SMI_LSB    = NUM_PINS;
  localparam int unsigned DB_EN_BIT  = NUM_PINS + NUM_SMI_PINS;

  logic [NUM_PINS-1:0]     dir_q, out_q;
  logic [NUM_SMI_PINS-1:0] smi_en_q;
  logic                    db_en_q;
  logic                    smi_q;

  logic [NUM_PINS-1:0]     pad_sync, level, chg;
  logic                    wr_cfg, wr_data, wr_stat, smi_set, smi_clr;

  assign wr_cfg  = wr_en_i && (addr_i == ADDR_CFG);
  assign wr_data = wr_en_i && (addr_i == ADDR_DATA);
  assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);

  gpio_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_i),
    .sync_o  (pad_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic bypass;
    if (p < NUM_SMI_PINS) begin : g_sel
      assign bypass = ~db_en_q;
    end else begin : g_fixed
      assign bypass = 1'b0;
    end
    gpio_debounce #(.DB_CYCLES(DB_CYCLES)) i_db (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sync_i   (pad_sync[p]),
      .bypass_i (bypass),
      .level_o  (level[p]),
      .chg_o    (chg[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '0;
      smi_en_q <= '0;
      db_en_q  <= 1'b0;
    end else if (wr_cfg) begin
      dir_q    <= wdata_i[NUM_PINS-1:0];
      smi_en_q <= wdata_i[SMI_LSB +: NUM_SMI_PINS];
      db_en_q  <= wdata_i[DB_EN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else if (wr_data) out_q <= (out_q & ~dir_q) | (wdata_i[NUM_PINS-1:0] & dir_q);
  end

  // events on input pads: SMI when enabled, else general routing
  logic [NUM_SMI_PINS-1:0] in_evt;
  assign in_evt     = chg[NUM_SMI_PINS-1:0] & ~dir_q[NUM_SMI_PINS-1:0];
  assign smi_set    = |(in_evt & smi_en_q);
  assign wake_evt_o = in_evt & ~smi_en_q;
  assign smi_clr    = wr_stat && wdata_i[STAT_SMI_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b0;
    else if (smi_set) smi_q <= 1'b1;
    else if (smi_clr) smi_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CFG: begin
        rdata_o[NUM_PINS-1:0]               = dir_q;
        rdata_o[SMI_LSB +: NUM_SMI_PINS]    = smi_en_q;
        rdata_o[DB_EN_BIT]                  = db_en_q;
      end
      ADDR_DATA: rdata_o[NUM_PINS-1:0]      = (out_q & dir_q) | (level & ~dir_q);
      ADDR_STAT: rdata_o[STAT_SMI_BIT]      = smi_q;
      default:   rdata_o                    = '0;
    endcase
  end

  assign pad_out_o = out_q;
  assign pad_oe_o  = dir_q;
  assign smi_o     = smi_q;
endmodule

// File: rtl/gpio_smi_port_chk.sv
module gpio_smi_port_chk
  import gpio_smi_pkg::*;
#(
  parameter int unsigned NP = 3,
  parameter int unsigned NS = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic [NP-1:0]     pad_out_o,
  input logic [NP-1:0]     pad_oe_o,
  input logic              smi_o,
  input logic [NS-1:0]     wake_evt_o,
  input logic [NP-1:0]     dir_q,
  input logic [NS-1:0]     smi_en_q
);
  localparam int unsigned CFG_W = NP + NS + 1;

  assert_oe_follows_cfg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CFG) |=> pad_oe_o == $past(wdata_i[NP-1:0]));

  assert_out_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_DATA) |=> $stable(pad_out_o));

  assert_input_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_DATA) |=> ((pad_out_o ^ $past(pad_out_o)) & ~$past(dir_q)) == '0);

  assert_smi_needs_input_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smi_o) |-> |($past(smi_en_q) & ~$past(dir_q[NS-1:0])));

  assert_smi_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_o && !(wr_en_i && addr_i == ADDR_STAT && wdata_i[STAT_SMI_BIT])) |=> smi_o);

  assert_wake_override_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_evt_o & smi_en_q) == '0);

  assert_cfg_reserved_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CFG) |-> rdata_o[REG_W-1:CFG_W] == '0);

  assert_stat_reserved_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_STAT) |-> rdata_o[REG_W-1:1] == '0);
endmodule

bind gpio_smi_port gpio_smi_port_chk #(.NP(NUM_PINS), .NS(NUM_SMI_PINS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .pad_out_o  (pad_out_o),
  .pad_oe_o   (pad_oe_o),
  .smi_o      (smi_o),
  .wake_evt_o (wake_evt_o),
  .dir_q      (dir_q),
  .smi_en_q   (smi_en_q)
);

// File: tb/test_gpio_smi_port.sv
module test_gpio_smi_port;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DB = 31;  // 31 us at 1 MHz
  localparam int unsigned WATCHDOG = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] pad_in = 3'b000;
  logic [2:0] pad_out, pad_oe;
  logic       smi;
  logic [1:0] wake;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gpio_smi_port i_gpio_smi_port (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .addr_i     (addr),
    .wr_en_i    (we),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .pad_in_i   (pad_in),
    .pad_out_o  (pad_out),
    .pad_oe_o   (pad_oe),
    .smi_o      (smi),
    .wake_evt_o (wake)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] a;
    logic [7:0] d;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 8'h00, 8'h00},  // R1 cfg reset
    '{1'b1, 2'd0, 8'hFF, 8'h3F},  // R11 cfg reserved bits dropped
    '{1'b1, 2'd1, 8'hFF, 8'h07},  // R4 all outputs read driven
    '{1'b1, 2'd0, 8'h03, 8'h03},  // R2 pad 2 input
    '{1'b1, 2'd1, 8'h00, 8'h00},  // R3 pad 2 reads level 0
    '{1'b1, 2'd0, 8'h07, 8'h07},  // R2 all outputs
    '{1'b0, 2'd1, 8'h00, 8'h04},  // R3 pad 2 kept old value
    '{1'b0, 2'd3, 8'h00, 8'h00},  // R11 address 3
    '{1'b1, 2'd3, 8'hFF, 8'h00},  // R11 address 3 write
    '{1'b0, 2'd2, 8'h00, 8'h00},  // R1 status reset
    '{1'b1, 2'd0, 8'h00, 8'h00},  // R2 back to inputs
    '{1'b0, 2'd1, 8'h00, 8'h00}   // R4 inputs read pad level 0
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic edges_then_sample(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pad_oe", {5'd0, pad_oe}, 8'h00);
    chk("R1 pad_out", {5'd0, pad_out}, 8'h00);
    chk("R1 smi", {7'd0, smi}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
      else @(negedge clk);
      rd(VECS[i].a, v);
      chk($sformatf("vector %0d (R1-R4/R11 table)", i), v, VECS[i].exp);
    end

    // R2 output enable tracks direction
    wr(2'd0, 8'h05);
    #1 chk("R2 pad_oe", {5'd0, pad_oe}, 8'h05);
    wr(2'd0, 8'h00);

    // R5 short pulse on pad 2 is filtered
    @(negedge clk);
    pad_in[2] = 1'b1;
    repeat (DB - 1) @(negedge clk);
    pad_in[2] = 1'b0;
    repeat (2 * DB + 4) @(negedge clk);
    rd(2'd1, v);
    chk("R5 glitch ignored", {7'd0, v[2]}, 8'h00);

    // R5 held level recognized at E(2+DB)
    @(negedge clk);
    pad_in[2] = 1'b1;
    edges_then_sample(1 + DB);
    rd(2'd1, v);
    chk("R5 before window", {7'd0, v[2]}, 8'h00);
    edges_then_sample(1);
    rd(2'd1, v);
    chk("R5 after window", {7'd0, v[2]}, 8'h01);

    // R6 direct path on pad 0, R10 wake pulse
    @(negedge clk);
    pad_in[0] = 1'b1;
    edges_then_sample(2);
    rd(2'd1, v);
    chk("R6 direct E2", {7'd0, v[0]}, 8'h00);
    chk("R10 wake pulse", {6'd0, wake}, 8'h01);
    edges_then_sample(1);
    rd(2'd1, v);
    chk("R6 direct E3", {7'd0, v[0]}, 8'h01);
    chk("R10 wake ends", {6'd0, wake}, 8'h00);
    chk("R8 no smi without enable", {7'd0, smi}, 8'h00);

    // R6 filtered path on pad 1
    wr(2'd0, 8'h20);
    pad_in[1] = 1'b1;
    edges_then_sample(1 + DB);
    rd(2'd1, v);
    chk("R6 filtered before", {7'd0, v[1]}, 8'h00);
    edges_then_sample(1);
    rd(2'd1, v);
    chk("R6 filtered after", {7'd0, v[1]}, 8'h01);

    // R7 SMI on pad 0, R10 override
    wr(2'd0, 8'h08);
    pad_in[0] = 1'b0;
    edges_then_sample(2);
    chk("R7 smi before E3", {7'd0, smi}, 8'h00);
    chk("R10 wake suppressed", {6'd0, wake}, 8'h00);
    edges_then_sample(1);
    chk("R7 smi at E3", {7'd0, smi}, 8'h01);
    rd(2'd2, v);
    chk("R7 status", v, 8'h01);

    // R9 write 0 keeps, write 1 clears
    wr(2'd2, 8'h00);
    #1 chk("R9 write 0 keeps", {7'd0, smi}, 8'h01);
    wr(2'd2, 8'h01);
    #1 chk("R9 write 1 clears", {7'd0, smi}, 8'h00);
    rd(2'd2, v);
    chk("R9 status cleared", v, 8'h00);

    // R8 output pad with SMI enable raises nothing
    wr(2'd0, 8'h09);
    pad_in[0] = 1'b1;
    repeat (6) @(negedge clk);
    #1 chk("R8 output pad no smi", {7'd0, smi}, 8'h00);
    wr(2'd0, 8'h08);
    pad_in[1] = 1'b0;
    repeat (6) @(negedge clk);
    #1 chk("R8 pad 1 not enabled", {7'd0, smi}, 8'h00);

    // R7 SMI on pad 1 through the filter
    wr(2'd0, 8'h30);
    pad_in[1] = 1'b1;
    edges_then_sample(1 + DB);
    chk("R7 pad 1 before", {7'd0, smi}, 8'h00);
    edges_then_sample(1);
    chk("R7 pad 1 after", {7'd0, smi}, 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule